// File: doc/BRIEF.md
# Page-Table Address Translation Unit

This block maps virtual addresses issued by an external-memory cache onto physical flash addresses. It holds a table of page entries. Each entry carries a physical page number, a valid flag and a sensitive flag. The page size is chosen at run time from four sizes, and the choice sets how many low address bits pass straight through as page offset.

Software reaches the table indirectly. It first writes an entry number to a selector register. A write to the content register then maps or unmaps that entry, and the content register reads the entry back. On a mapping write, the valid flag is added by the block. The sensitive flag is added as well when a 3-bit fuse counter has odd parity.

The cache side presents a virtual address on a request strobe. One cycle later it gets the physical address, a hit flag and the sensitive flag of the chosen entry.

Top module: `pgxlat_top`

## Requirements
- R1: The page-size register (select code 2, bits [1:0]) resets to 0. The page shift is 16, 15, 14 or 13 for codes 0, 1, 2 or 3, giving 64, 32, 16 or 8 KB pages. The register reads back its code and changes only on a write to select code 2.
- R2: The entry for a translation is the low `log2(ENTRIES)+16` bits of the virtual address shifted right by the page shift. A result at or beyond ENTRIES is a miss.
- R3: A write to select code 0 stores the entry index. A later write to select code 1 updates the entry at that index, and a read of select code 1 returns it.
- R4: A content read returns the stored physical page number, zero-extended, for a valid entry and zero for an invalid entry. The sensitive flag never appears in read data.
- R5: A content write with bit 31 clear maps the entry: it stores bits [PPN_W-1:0] as the page number and sets the valid flag. A content write with bit 31 set unmaps the entry.
- R6: A mapping write sets the entry's sensitive flag exactly when the 3-bit fuse input has an odd number of ones. The flag is reported on `xl_secure` for hits.
- R7: On a hit, the physical address equals the page number shifted left by the page shift, ORed with the virtual address bits below the shift. On a miss, `xl_hit`, `xl_secure` and `xl_paddr` are zero.
- R8: After reset, every entry is invalid. Every translation misses and every content read returns zero.
- R9: If the stored index is at or beyond ENTRIES, content writes change no entry and content reads return zero.
- R10: `xl_ack` pulses exactly one cycle after each `xl_req`, with the results of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 content, 2 page size |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data of the selected register (combinational) |
| fuse_cnt | input | 3 | Fuse counter; odd parity enables the sensitive flag |
| xl_req | input | 1 | Translation request |
| xl_vaddr | input | AW | Virtual address to translate |
| xl_ack | output | 1 | Translation result valid |
| xl_hit | output | 1 | Selected entry exists and is valid |
| xl_paddr | output | AW | Translated physical address |
| xl_secure | output | 1 | Sensitive flag of the hit entry |

## Verification
One set of virtual addresses is translated under all four page-size codes. Because the same address then selects different entries and keeps different offset widths, a fault in the shift selection shows up at once. Addresses are placed at the first entry, at the last entry and past the end of the table under 8 KB pages, which separates a correct range check from index wrap-around. Mapping writes are made with even and odd fuse patterns and followed by unmaps, so the sensitive flag and the valid flag are tested apart. An out-of-range index is paired with a write and then a re-read of entry 0, to show the write was dropped rather than aliased.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;

   typedef enum logic [1:0] {
      SEL_INDEX   = 2'd0,
      SEL_CONTENT = 2'd1,
      SEL_SIZE    = 2'd2,
      SEL_NONE    = 2'd3
   } reg_sel_e;

   localparam int unsigned MAX_SHIFT = 16;
   localparam int unsigned MIN_SHIFT = 13;

   function automatic logic [4:0] shift_of(input logic [1:0] code);
      return 5'(MAX_SHIFT) - {3'b000, code};
   endfunction

endpackage

// File: rtl/pgxlat_size.sv
module pgxlat_size
   import pgxlat_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_code,
   output logic [1:0] code,
   output logic [4:0] shift
);

   logic [1:0] code_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     code_q <= 2'd0;
      else if (wr_en) code_q <= wr_code;
   end

   assign code  = code_q;
   assign shift = shift_of(code_q);

   p_code_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(code_q));

   p_shift_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (shift >= 5'(MIN_SHIFT)) && (shift <= 5'(MAX_SHIFT)));

endmodule

// File: rtl/pgxlat_table.sv
module pgxlat_table #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned AW      = 32,
   parameter int unsigned PPN_W   = 14,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_wr,
   input  logic             cont_wr,
   input  logic [AW-1:0]    wdata,
   input  logic             enc_on,
   output logic [AW-1:0]    cont_rdata,
   input  logic [IDX_W-1:0] lk_idx,
   output logic             lk_valid,
   output logic             lk_sens,
   output logic [PPN_W-1:0] lk_ppn
);

   logic [IDX_W-1:0]   idx_q;
   logic               idx_oor_q;
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] sens_q;
   logic [PPN_W-1:0]   ppn_q [ENTRIES];
   logic               wr_ok;
   logic               unmap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q     <= '0;
         idx_oor_q <= 1'b0;
      end else if (idx_wr) begin
         idx_q     <= wdata[IDX_W-1:0];
         idx_oor_q <= (wdata >= AW'(ENTRIES));
      end
   end

   assign wr_ok = cont_wr && !idx_oor_q;
   assign unmap = wdata[AW-1];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic             v_q;
      logic             s_q;
      logic [PPN_W-1:0] p_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= 1'b0;
            p_q <= '0;
         end else if (wr_ok && (idx_q == IDX_W'(g))) begin
            v_q <= !unmap;
            s_q <= !unmap && enc_on;
            p_q <= unmap ? '0 : wdata[PPN_W-1:0];
         end
      end
      assign valid_q[g] = v_q;
      assign sens_q[g]  = s_q;
      assign ppn_q[g]   = p_q;
   end

   assign cont_rdata = (!idx_oor_q && valid_q[idx_q]) ? AW'(ppn_q[idx_q]) : '0;
   assign lk_valid   = valid_q[lk_idx];
   assign lk_sens    = sens_q[lk_idx];
   assign lk_ppn     = ppn_q[lk_idx];

   p_oor_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cont_wr && idx_oor_q) |=> ($stable(valid_q) && $stable(sens_q)));

   p_oor_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idx_oor_q |-> (cont_rdata == '0));

   p_sens_implies_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_q & ~valid_q) == '0);

endmodule

// File: rtl/pgxlat_lookup.sv
module pgxlat_lookup #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned AW      = 32,
   parameter int unsigned PPN_W   = 14,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned VSPAN  = IDX_W + pgxlat_pkg::MAX_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       shift,
   input  logic             xl_req,
   input  logic [AW-1:0]    xl_vaddr,
   output logic [IDX_W-1:0] lk_idx,
   input  logic             lk_valid,
   input  logic             lk_sens,
   input  logic [PPN_W-1:0] lk_ppn,
   output logic             xl_ack,
   output logic             xl_hit,
   output logic [AW-1:0]    xl_paddr,
   output logic             xl_secure
);

   logic [VSPAN-1:0] vsel;
   logic             in_tab;
   logic             hit_c;
   logic [AW-1:0]    offmask;
   logic [AW-1:0]    pa_c;
   logic             ack_q, hit_q, sec_q;
   logic [AW-1:0]    pa_q;

   assign vsel    = xl_vaddr[VSPAN-1:0] >> shift;
   assign in_tab  = (vsel < VSPAN'(ENTRIES));
   assign lk_idx  = vsel[IDX_W-1:0];
   assign hit_c   = in_tab && lk_valid;
   assign offmask = (AW'(1) << shift) - AW'(1);
   assign pa_c    = (AW'(lk_ppn) << shift) | (xl_vaddr & offmask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         hit_q <= 1'b0;
         sec_q <= 1'b0;
         pa_q  <= '0;
      end else begin
         ack_q <= xl_req;
         if (xl_req) begin
            hit_q <= hit_c;
            sec_q <= hit_c && lk_sens;
            pa_q  <= hit_c ? pa_c : '0;
         end
      end
   end

   assign xl_ack    = ack_q;
   assign xl_hit    = hit_q;
   assign xl_secure = sec_q;
   assign xl_paddr  = pa_q;

   p_ack_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req |=> xl_ack);

   p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_ack && !xl_hit) |-> (xl_paddr == '0 && !xl_secure));

   p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_ack && xl_hit) |-> (xl_paddr[12:0] == $past(xl_vaddr[12:0])));

endmodule

// File: rtl/pgxlat_top.sv
module pgxlat_top
   import pgxlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned AW      = 32,
   parameter int unsigned PPN_W   = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_sel,
   input  logic [AW-1:0] reg_wdata,
   output logic [AW-1:0] reg_rdata,
   input  logic [2:0]    fuse_cnt,
   input  logic          xl_req,
   input  logic [AW-1:0] xl_vaddr,
   output logic          xl_ack,
   output logic          xl_hit,
   output logic [AW-1:0] xl_paddr,
   output logic          xl_secure
);

   localparam int unsigned IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (PPN_W + MAX_SHIFT > AW - 1) begin : g_bad_ppn
      $error("PPN_W plus the largest page shift must leave the top bit free");
   end
   if (IDX_W + MAX_SHIFT > AW) begin : g_bad_span
      $error("virtual span exceeds address width");
   end

   reg_sel_e         sel;
   logic [1:0]       code;
   logic [4:0]       shift;
   logic [AW-1:0]    cont_rdata;
   logic [IDX_W-1:0] lk_idx;
   logic             lk_valid, lk_sens;
   logic [PPN_W-1:0] lk_ppn;
   logic             enc_on;

   assign sel    = reg_sel_e'(reg_sel);
   assign enc_on = ^fuse_cnt;

   pgxlat_size u_size (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && sel == SEL_SIZE),
      .wr_code (reg_wdata[1:0]),
      .code    (code),
      .shift   (shift)
   );

   pgxlat_table #(.ENTRIES(ENTRIES), .AW(AW), .PPN_W(PPN_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_wr     (reg_wr && sel == SEL_INDEX),
      .cont_wr    (reg_wr && sel == SEL_CONTENT),
      .wdata      (reg_wdata),
      .enc_on     (enc_on),
      .cont_rdata (cont_rdata),
      .lk_idx     (lk_idx),
      .lk_valid   (lk_valid),
      .lk_sens    (lk_sens),
      .lk_ppn     (lk_ppn)
   );

   pgxlat_lookup #(.ENTRIES(ENTRIES), .AW(AW), .PPN_W(PPN_W)) u_lookup (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift     (shift),
      .xl_req    (xl_req),
      .xl_vaddr  (xl_vaddr),
      .lk_idx    (lk_idx),
      .lk_valid  (lk_valid),
      .lk_sens   (lk_sens),
      .lk_ppn    (lk_ppn),
      .xl_ack    (xl_ack),
      .xl_hit    (xl_hit),
      .xl_paddr  (xl_paddr),
      .xl_secure (xl_secure)
   );

   always_comb begin
      unique case (sel)
         SEL_CONTENT: reg_rdata = cont_rdata;
         SEL_SIZE:    reg_rdata = AW'(code);
         default:     reg_rdata = '0;
      endcase
   end

endmodule

// File: tb/pgxlat_top_tb.sv
module pgxlat_top_tb;

   localparam int ENT = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  fuse_cnt = 3'b000;
   logic        xl_req = 1'b0;
   logic [31:0] xl_vaddr = '0;
   logic        xl_ack, xl_hit, xl_secure;
   logic [31:0] xl_paddr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   int m_idx = 0;
   int m_code = 0;
   bit m_valid [ENT];
   bit m_sens [ENT];
   int m_ppn [ENT];
   bit req_seen = 0;

   always #5 clk = ~clk;

   pgxlat_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fuse_cnt(fuse_cnt),
      .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_ack(xl_ack), .xl_hit(xl_hit),
      .xl_paddr(xl_paddr), .xl_secure(xl_secure)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R10: acknowledge compared on every clock against a one-cycle-delayed copy of the request
   always @(posedge clk) req_seen <= rst_n && xl_req;
   always @(negedge clk) if (rst_n && !done) chk(xl_ack == req_seen, "R10 ack", xl_ack, req_seen);

   task automatic wr(input int sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel[1:0]; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 2'd3;
      if (sel == 0) m_idx = d;
      else if (sel == 2) m_code = d[1:0];
      else if (sel == 1 && m_idx < ENT) begin
         if (d[31]) begin
            m_valid[m_idx] = 0; m_sens[m_idx] = 0; m_ppn[m_idx] = 0;
         end else begin
            m_valid[m_idx] = 1; m_sens[m_idx] = ^fuse_cnt; m_ppn[m_idx] = d[13:0];
         end
      end
   endtask

   task automatic rd(input int sel, input string req);
      longint exp;
      reg_sel = sel[1:0];
      #1;
      if (sel == 2) exp = m_code;
      else if (sel == 1) exp = (m_idx < ENT && m_valid[m_idx]) ? m_ppn[m_idx] : 0;
      else exp = 0;
      chk(reg_rdata == exp[31:0], req, reg_rdata, exp);
      reg_sel = 2'd3;
   endtask

   task automatic xl(input logic [31:0] va, input string req);
      int sh;
      longint eidx, epa;
      bit eh, es;
      @(negedge clk);
      xl_req = 1'b1; xl_vaddr = va;
      sh = 16 - m_code;
      eidx = (va & 32'h003F_FFFF) >> sh;
      eh = (eidx < ENT) && m_valid[eidx];
      es = eh && m_sens[eidx];
      epa = eh ? ((longint'(m_ppn[eidx]) << sh) | (va & ((32'h1 << sh) - 1))) : 0;
      @(negedge clk);
      xl_req = 1'b0;
      chk(xl_hit == eh, {req, " hit"}, xl_hit, eh);
      chk(xl_paddr == epa[31:0], {req, " paddr"}, xl_paddr, epa);
      chk(xl_secure == es, {req, " secure"}, xl_secure, es);
   endtask

   task automatic sweep(input string req);
      xl(32'h4200_0000, req);
      xl(32'h4201_2345, req);
      xl(32'h4205_6789, req);
      xl(32'h423F_FFFF, req);
      xl(32'h4208_1FFF, req);
   endtask

   initial begin
      #3_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < ENT; i++) begin
         m_valid[i] = 0; m_sens[i] = 0; m_ppn[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 R1: reset state
      rd(2, "R1 reset code");
      rd(1, "R8 reset content");
      xl(32'h4200_0000, "R8 reset miss");
      // R3 R5: map a spread of entries
      wr(0, 0);  wr(1, 32'h0000_0123); rd(1, "R3 R4 read entry 0");
      wr(0, 1);  wr(1, 32'h0000_3ABC); rd(1, "R3 R4 read entry 1");
      wr(0, 5);  wr(1, 32'h0000_0777);
      wr(0, 63); wr(1, 32'h0000_1FFF); rd(1, "R5 read entry 63");
      wr(0, 2);  rd(1, "R4 unmapped entry reads zero");
      // R2 R7: translations under all four page sizes
      sweep("R7 code0");
      wr(2, 1); rd(2, "R1 code1"); sweep("R2 code1");
      wr(2, 2); rd(2, "R1 code2"); sweep("R2 code2");
      wr(2, 3); rd(2, "R1 code3"); sweep("R2 code3");
      xl(32'h0000_2000, "R2 8KB entry1");
      xl(32'h0008_0000, "R2 8KB beyond table");
      wr(2, 0);
      // R6: sensitive flag by fuse parity
      fuse_cnt = 3'b001; wr(0, 7); wr(1, 32'h0000_0042);
      fuse_cnt = 3'b011; wr(0, 8); wr(1, 32'h0000_0043);
      fuse_cnt = 3'b111; wr(0, 9); wr(1, 32'h0000_0044);
      fuse_cnt = 3'b000;
      wr(0, 7); rd(1, "R6 read hides sensitive");
      xl(32'h4207_0010, "R6 odd one");
      xl(32'h4208_0020, "R6 even");
      xl(32'h4209_0030, "R6 odd three");
      // R5: unmap
      wr(0, 5); wr(1, 32'h8000_0000); rd(1, "R5 unmapped read");
      xl(32'h4205_0000, "R5 unmapped miss");
      // R9: out-of-range index
      wr(0, 64); wr(1, 32'h0000_0555); rd(1, "R9 oor read zero");
      wr(0, 0); rd(1, "R9 entry0 untouched");
      xl(32'h4200_0004, "R9 entry0 translate");
      wr(0, 200); wr(1, 32'h8000_0000);
      wr(0, 0); rd(1, "R9 oor unmap ignored");
      // R1: no size change from other writes
      wr(0, 3); rd(2, "R1 code unchanged");
      sweep("R7 final");
      done = 1;
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule